// File: doc/BRIEF.md
# Lock-Step Pack/Unpack Move Index Generator

This block produces the sequence of element offsets for a vector register move whose elements are small groups of one to four components. Two index walkers run side by side, one for the source and one for the destination, and both advance by one step on the same cycle. Each output pair names one move: from source base plus source offset to destination base plus destination offset. The caller adds the base register numbers.

Each walker chooses its addressing on its own. In element-major addressing, offsets follow the natural interleaved layout. In component-major (transposed) addressing, all first components come first, then all second components, and so on. With the source walker transposed, one pass gathers a planar layout into interleaved groups (pack). With the destination walker transposed, one pass scatters interleaved groups into planes (unpack). Both may be transposed at once. The result is still fully deterministic.

The caller starts a sequence with a one-cycle start pulse. Pairs are then handed over with a valid/ready handshake. A one-cycle done pulse closes each sequence.

Top module: `mvidx_pair_gen`

## Requirements
- R1: After reset, `pairValid` and `seqDone` are low. They stay low until a start is accepted.
- R2: `grpCode` gives the group size as code+1, so 0 means 1 component and 3 means 4 components. A `vecLen` above 64 is treated as 64. Both values and both order selects are captured when a start is accepted.
- R3: Both walkers step through the index pairs (i, j) in the same order: i (element, 0..VL-1) is the outer loop and j (component, 0..S-1) is the inner loop. An element-major walker emits offset i*S+j.
- R4: A transposed walker emits offset i + VL*j for the same (i, j). The source walker is transposed when `packSel` is high.
- R5: The destination walker is transposed when `unpackSel` is high. Each select acts only on its own side, and both may be high together.
- R6: For VL ≥ 1, exactly VL*S pairs are emitted. The first pair is valid in the cycle after start is accepted. `seqDone` goes high for exactly one cycle, in the cycle after the last pair's handshake. `pairValid` is never high in that cycle, and the block then returns to idle.
- R7: A start with `vecLen` equal to 0 emits no pairs and raises `seqDone` in the next cycle.
- R8: The walkers advance only in a cycle with `pairValid` and `pairReady` both high. While `pairReady` is low, both offsets and `pairValid` hold.
- R9: A start while a sequence is running or during the done cycle is ignored. Changes to the length, group or select inputs during that time have no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence (accepted only when idle) |
| vecLen | input | 7 | Number of elements, VL (values above 64 are clamped to 64) |
| grpCode | input | 2 | Components per element minus one |
| packSel | input | 1 | Source walker uses transposed addressing |
| unpackSel | input | 1 | Destination walker uses transposed addressing |
| pairReady | input | 1 | Consumer accepts the current pair |
| srcOff | output | 8 | Source element offset |
| dstOff | output | 8 | Destination element offset |
| pairValid | output | 1 | Offset pair is valid |
| seqDone | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The bench compares every cycle against a behavioural model built from queues. It covers the following cases:

- **Group size of one.** Transposed addressing then reduces to the identity. A walker that picked the wrong stride at row wrap would show up here.
- **Four-component groups and the 64-element maximum.** These reach offset 255. A walker that wrapped early or reloaded its row offset badly would emit repeated or skipped offsets.
- **Zero-length starts.** A design that entered the running state would raise `pairValid` or delay `seqDone`.
- **Randomly stalled ready.** A design that stepped without a handshake would drop pairs.
- **Start held high through a whole run and its done cycle, with the length and selects changed mid-run.** A design that re-captured its configuration would restart or change order.

// File: rtl/mvidx_pkg.sv
package mvidx_pkg;

  // Strobes sent from the sequencer to the walker datapath.
  typedef struct packed {
    logic load;  // capture configuration, clear both walkers
    logic step;  // advance both walkers by one index pair
  } walkCtl_t;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_FIN  = 2'd2
  } seqState_t;

endpackage

// File: rtl/mvidx_walker.sv
module mvidx_walker
  import mvidx_pkg::*;
#(
  parameter int MAX_VL  = 64,
  parameter int MAX_SUB = 4,
  localparam int VL_W  = $clog2(MAX_VL + 1),
  localparam int SUB_W = $clog2(MAX_SUB),
  localparam int CNT_W = $clog2(MAX_VL),
  localparam int OFF_W = $clog2(MAX_VL * MAX_SUB)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  walkCtl_t         ctl,
  input  logic [VL_W-1:0]  vl,
  input  logic [SUB_W-1:0] subM1,
  input  logic             transp,
  output logic [OFF_W-1:0] runOff,
  output logic             isLast
);

  logic [CNT_W-1:0] cntI;
  logic [SUB_W-1:0] cntJ;
  logic [OFF_W-1:0] rowOff;
  logic [OFF_W-1:0] colStride;
  logic [OFF_W-1:0] rowStride;
  logic             rowEnd;

  // Element-major: +1 per component, +S per element.
  // Transposed:    +VL per component, +1 per element.
  assign colStride = transp ? OFF_W'(vl) : OFF_W'(1);
  assign rowStride = transp ? OFF_W'(1)  : OFF_W'(subM1) + OFF_W'(1);
  assign rowEnd    = (cntJ == subM1);
  assign isLast    = rowEnd && (VL_W'(cntI) == vl - VL_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cntI   <= '0;
      cntJ   <= '0;
      rowOff <= '0;
      runOff <= '0;
    end else if (ctl.load) begin
      cntI   <= '0;
      cntJ   <= '0;
      rowOff <= '0;
      runOff <= '0;
    end else if (ctl.step) begin
      if (rowEnd) begin
        cntJ   <= '0;
        cntI   <= cntI + CNT_W'(1);
        rowOff <= rowOff + rowStride;
        runOff <= rowOff + rowStride;
      end else begin
        cntJ   <= cntJ + SUB_W'(1);
        runOff <= runOff + colStride;
      end
    end
  end

  assert_j_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cntJ <= subM1);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.step && !ctl.load) |=> $stable(runOff));

endmodule

// File: rtl/mvidx_datapath.sv
module mvidx_datapath
  import mvidx_pkg::*;
#(
  parameter int MAX_VL  = 64,
  parameter int MAX_SUB = 4,
  localparam int VL_W  = $clog2(MAX_VL + 1),
  localparam int SUB_W = $clog2(MAX_SUB),
  localparam int OFF_W = $clog2(MAX_VL * MAX_SUB),
  localparam int SIDES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  walkCtl_t         ctl,
  input  logic [VL_W-1:0]  vecLen,
  input  logic [SUB_W-1:0] grpCode,
  input  logic             packSel,
  input  logic             unpackSel,
  output logic [OFF_W-1:0] srcOff,
  output logic [OFF_W-1:0] dstOff,
  output logic             isLast
);

  logic [VL_W-1:0]  vlClamp;
  logic [VL_W-1:0]  vlReg;
  logic [SUB_W-1:0] subReg;
  logic             packReg;
  logic             unpackReg;
  logic [OFF_W-1:0] sideOff  [SIDES];
  logic             sideLast [SIDES];

  assign vlClamp = (vecLen > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : vecLen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vlReg     <= '0;
      subReg    <= '0;
      packReg   <= 1'b0;
      unpackReg <= 1'b0;
    end else if (ctl.load) begin
      vlReg     <= vlClamp;
      subReg    <= grpCode;
      packReg   <= packSel;
      unpackReg <= unpackSel;
    end
  end

  // Side 0 walks the source, side 1 the destination.
  for (genvar g = 0; g < SIDES; g++) begin : g_side
    mvidx_walker #(
      .MAX_VL (MAX_VL),
      .MAX_SUB(MAX_SUB)
    ) u_walk (
      .clk   (clk),
      .rst_n (rst_n),
      .ctl   (ctl),
      .vl    (vlReg),
      .subM1 (subReg),
      .transp((g == 0) ? packReg : unpackReg),
      .runOff(sideOff[g]),
      .isLast(sideLast[g])
    );
  end

  assign srcOff = sideOff[0];
  assign dstOff = sideOff[1];
  assign isLast = sideLast[0];

  assert_lockstep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sideLast[0] == sideLast[1]);

endmodule

// File: rtl/mvidx_ctrl.sv
module mvidx_ctrl
  import mvidx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     vlZero,
  input  logic     ready,
  input  logic     isLast,
  output walkCtl_t ctl,
  output logic     outValid,
  output logic     done
);

  seqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    ctl       = '0;
    unique case (state)
      SEQ_IDLE: begin
        if (start) begin
          ctl.load  = 1'b1;
          stateNext = vlZero ? SEQ_FIN : SEQ_RUN;
        end
      end
      SEQ_RUN: begin
        if (ready) begin
          ctl.step = 1'b1;
          if (isLast) stateNext = SEQ_FIN;
        end
      end
      SEQ_FIN:  stateNext = SEQ_IDLE;
      default:  stateNext = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= SEQ_IDLE;
    else        state <= stateNext;
  end

  assign outValid = (state == SEQ_RUN);
  assign done     = (state == SEQ_FIN);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && outValid));

  assert_zero_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!outValid && !done && start && vlZero) |=> (done && !outValid));

  assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !ready) |=> outValid);

  assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid || done) |-> !ctl.load);

endmodule

// File: rtl/mvidx_pair_gen.sv
module mvidx_pair_gen
  import mvidx_pkg::*;
#(
  parameter int MAX_VL  = 64,
  parameter int MAX_SUB = 4,
  localparam int VL_W  = $clog2(MAX_VL + 1),
  localparam int SUB_W = $clog2(MAX_SUB),
  localparam int OFF_W = $clog2(MAX_VL * MAX_SUB)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VL_W-1:0]  vecLen,
  input  logic [SUB_W-1:0] grpCode,
  input  logic             packSel,
  input  logic             unpackSel,
  input  logic             pairReady,
  output logic [OFF_W-1:0] srcOff,
  output logic [OFF_W-1:0] dstOff,
  output logic             pairValid,
  output logic             seqDone
);

  walkCtl_t walkCtl;
  logic     lastPair;

  mvidx_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .vlZero  (vecLen == '0),
    .ready   (pairReady),
    .isLast  (lastPair),
    .ctl     (walkCtl),
    .outValid(pairValid),
    .done    (seqDone)
  );

  mvidx_datapath #(
    .MAX_VL (MAX_VL),
    .MAX_SUB(MAX_SUB)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (walkCtl),
    .vecLen   (vecLen),
    .grpCode  (grpCode),
    .packSel  (packSel),
    .unpackSel(unpackSel),
    .srcOff   (srcOff),
    .dstOff   (dstOff),
    .isLast   (lastPair)
  );

endmodule

// File: tb/mvidx_pair_gen_bench.sv
`timescale 1ns/1ps
module mvidx_pair_gen_bench;
  localparam int MAX_VL = 64;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [6:0] vecLen;
  logic [1:0] grpCode;
  logic       packSel, unpackSel, pairReady;
  logic [7:0] srcOff, dstOff;
  logic       pairValid, seqDone;

  always #2 clk = ~clk;

  mvidx_pair_gen u_mvidx_pair_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .vecLen(vecLen),
    .grpCode(grpCode), .packSel(packSel), .unpackSel(unpackSel),
    .pairReady(pairReady), .srcOff(srcOff), .dstOff(dstOff),
    .pairValid(pairValid), .seqDone(seqDone)
  );

  int    checks = 0;
  int    errors = 0;
  int    cyc    = 0;
  string curTag = "R1";
  bit    mPack, mUnpack;
  bit    mZero;

  // Behavioural reference: 0 idle, 1 running, 2 done cycle.
  int mState = 0;
  int mSrc[$];
  int mDst[$];

  task automatic check(string what, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s [%s]: got %0d expected %0d", tag, what, curTag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int v, s;
    if (!rst_n) begin
      mState = 0;
      mSrc.delete();
      mDst.delete();
    end else begin
      case (mState)
        0: if (start) begin
          v = (vecLen > MAX_VL) ? MAX_VL : int'(vecLen);
          s = int'(grpCode) + 1;
          mPack = packSel; mUnpack = unpackSel; mZero = (v == 0);
          if (v == 0) mState = 2;
          else begin
            for (int i = 0; i < v; i++)
              for (int j = 0; j < s; j++) begin
                mSrc.push_back(packSel   ? i + v*j : i*s + j);
                mDst.push_back(unpackSel ? i + v*j : i*s + j);
              end
            mState = 1;
          end
        end
        1: if (pairReady) begin
          void'(mSrc.pop_front());
          void'(mDst.pop_front());
          if (mSrc.size() == 0) mState = 2;
        end
        default: mState = 0;
      endcase
    end
  end

  // Compare on every cycle, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      check("pairValid", "R6", 32'(pairValid), 32'(mState == 1));
      check("seqDone", mZero ? "R7" : "R6", 32'(seqDone), 32'(mState == 2));
      if (mState == 1 && mSrc.size() > 0) begin
        check("srcOff", mPack ? "R4" : "R3", 32'(srcOff), 32'(mSrc[0]));
        check("dstOff", mUnpack ? "R5" : "R3", 32'(dstOff), 32'(mDst[0]));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog [%s]: got %0d expected %0d", curTag, cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  logic [15:0] lfsr = 16'hACE1;

  task automatic runSeq(int vl, int code, bit pk, bit upk, bit stall, bit disturb);
    @(negedge clk);
    vecLen = 7'(vl); grpCode = 2'(code); packSel = pk; unpackSel = upk;
    start = 1'b1; pairReady = 1'b1;
    forever begin
      @(negedge clk);
      if (mState == 0) break;
      if (disturb) begin
        start = 1'b1; vecLen = 7'(vl + 3); grpCode = 2'(code ^ 1);
        packSel = ~pk; unpackSel = ~upk;
      end else start = 1'b0;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pairReady = stall ? lfsr[0] : 1'b1;
    end
    start = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; vecLen = '0; grpCode = '0;
    packSel = 1'b0; unpackSel = 1'b0; pairReady = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    curTag = "R1";
    check("reset pairValid", "R1", 32'(pairValid), 32'd0);
    check("reset seqDone", "R1", 32'(seqDone), 32'd0);

    curTag = "R3"; runSeq(5, 0, 0, 0, 0, 0);
    curTag = "R3"; runSeq(5, 3, 0, 0, 0, 0);
    curTag = "R4"; runSeq(4, 2, 1, 0, 0, 0);
    curTag = "R4"; runSeq(7, 0, 1, 0, 0, 0);
    curTag = "R5"; runSeq(3, 3, 0, 1, 0, 0);
    curTag = "R5"; runSeq(6, 1, 1, 1, 0, 0);
    curTag = "R7"; runSeq(0, 2, 1, 0, 0, 0);
    curTag = "R6"; runSeq(1, 0, 0, 0, 0, 0);
    curTag = "R2"; runSeq(100, 3, 1, 0, 0, 0);
    curTag = "R6"; runSeq(64, 3, 1, 1, 0, 0);
    curTag = "R8"; runSeq(7, 2, 1, 0, 1, 0);
    curTag = "R8"; runSeq(9, 3, 0, 1, 1, 0);
    curTag = "R9"; runSeq(5, 2, 1, 0, 0, 1);
    curTag = "R9"; runSeq(4, 1, 0, 1, 1, 1);
    curTag = "R7"; runSeq(0, 0, 0, 0, 0, 1);
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule